// File: doc/BRIEF.md
# Masked IR Wake Pattern Matcher

This block lets a sleeping system wake on one particular infrared command. Software loads a reference pattern and a bit mask, each eleven bytes, through a small byte-wide register bus. Writes go through an index register, and each write to the data register steps the index forward. Demodulated symbol bytes arrive on a stream input. They are compared in arrival order against the stored pattern, position by position. Only the bits set in the mask take part in the comparison.

An end-of-message strobe closes each message and updates a set of sticky status flags: a full match, a message end, an overflow of the eleven-byte window, and an empty message (repeat code). Each of the first three flags has its own enable bit. The wake output is high while any enabled flag is set. Software clears a flag by writing 1 to its bit.

The symbol stream uses a valid/ready handshake. The block never applies back-pressure: `sym_ready` is held high, and a byte counts as accepted in every cycle in which `sym_valid` is high. The end-of-message strobe `sym_eom` is sampled separately from `sym_valid`. When both are high in the same cycle, the byte counts as part of the message before the message is judged.

Top module: `irwake_matcher`

## Requirements
- R1: A write to INDEX (address 3) stores bits 5:0. Bit 4 selects the compare bank, bit 5 selects the mask bank, and bits 3:0 give the byte address. Each write to DATA (address 4) stores the byte at that address in every selected bank if the address is below 11, then increments bits 3:0 modulo 16. A read of DATA returns the addressed byte: the compare byte when bit 4 is set, otherwise the mask byte.
- R2: A received byte at position p, where p is below the effective length, mismatches when ((byte XOR compare[p]) AND mask[p]) is nonzero. Mask bits that are 0 never cause a mismatch.
- R3: MATCH (status bit 0) is set at end-of-message when the message is not empty, at least the effective length of bytes arrived, and no counted position mismatched. The effective length is LEN (address 5, bits 3:0) clamped to 11. Bytes beyond the effective length are not compared.
- R4: MSG_END (status bit 1) is set by every accepted end-of-message strobe.
- R5: A byte arriving when 11 bytes of the current message are already held sets BUFF (status bit 2) and takes no part in matching.
- R6: An end-of-message strobe with no byte in the message sets REPEAT (status bit 4) and never sets MATCH.
- R7: Writing STATUS (address 1) clears each implemented bit written as 1. An event that sets a bit in the same cycle wins over the clear.
- R8: `wake` is high exactly while status bits 2:0 ANDed with EVENT_EN (address 2, bits 2:0, same bit order) are nonzero. REPEAT never drives `wake`.
- R9: While CTRL (address 0) bit 0 is 0, symbol bytes and end-of-message strobes are ignored, no status bit is set, and the partial message is discarded.
- R10: `sym_ready` is always 1, so every valid byte is accepted in its cycle.
- R11: After reset all registers and both pattern banks read 0 and `wake` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| sym_valid | input | 1 | Symbol byte valid |
| sym_ready | output | 1 | Symbol byte ready, always 1 |
| sym_data | input | 8 | Demodulated symbol byte |
| sym_eom | input | 1 | End-of-message strobe |
| wake | output | 1 | Wake request |

## Verification
Any register write, accepted byte or end-of-message strobe takes effect at the clock edge that samples it. The new status and `wake` are therefore visible right after that edge. `reg_rdata` follows `reg_addr` with no delay. The bench drives inputs on the falling edge. It advances its reference model on the rising edge and compares `wake`, `sym_ready` and the status readback 5 ns after every rising edge. Directed reads are taken 1 ns after the address is set, so every check lands one edge after its stimulus and never at the edge itself.

// File: rtl/irwake_pkg.sv
package irwake_pkg;
  localparam int unsigned SYM_W = 8;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_STAT  = 3'd1;
  localparam logic [2:0] A_EVEN  = 3'd2;
  localparam logic [2:0] A_INDEX = 3'd3;
  localparam logic [2:0] A_DATA  = 3'd4;
  localparam logic [2:0] A_LEN   = 3'd5;

  localparam int unsigned ST_MATCH = 0;
  localparam int unsigned ST_END   = 1;
  localparam int unsigned ST_BUFF  = 2;
  localparam int unsigned ST_REP   = 4;
  localparam logic [7:0]  ST_IMPL  = 8'h17;

  localparam int unsigned IX_CMP = 4;
  localparam int unsigned IX_MSK = 5;
  localparam int unsigned IX_AW  = 4;

  typedef struct packed {
    logic match;
    logic msg_end;
    logic buff;
    logic rep;
  } evt_t;
endpackage

// File: rtl/irwake_patmem.sv
module irwake_patmem
  import irwake_pkg::*;
#(
  parameter int unsigned NB = 11,
  parameter int unsigned PW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic             dat_wr,
  input  logic [SYM_W-1:0] wdata,
  input  logic [PW-1:0]    rd_pos,
  output logic [7:0]       idx_q,
  output logic [SYM_W-1:0] cmp_byte,
  output logic [SYM_W-1:0] msk_byte,
  output logic [SYM_W-1:0] rb_byte
);
  logic [SYM_W-1:0] cmp_arr [NB];
  logic [SYM_W-1:0] msk_arr [NB];
  logic [IX_AW-1:0] waddr;
  logic             sel_cmp, sel_msk;

  assign waddr   = idx_q[IX_AW-1:0];
  assign sel_cmp = idx_q[IX_CMP];
  assign sel_msk = idx_q[IX_MSK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_wr) begin
      idx_q <= {2'b00, wdata[5:0]};
    end else if (dat_wr) begin
      idx_q[IX_AW-1:0] <= waddr + 1'b1;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_byte
    localparam logic [IX_AW-1:0] MY_ADDR = IX_AW'(g);
    logic [SYM_W-1:0] cmp_r, msk_r;
    logic             hit;
    assign hit = dat_wr && (waddr == MY_ADDR);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_r <= '0;
        msk_r <= '0;
      end else if (hit) begin
        if (sel_cmp) cmp_r <= wdata;
        if (sel_msk) msk_r <= wdata;
      end
    end
    assign cmp_arr[g] = cmp_r;
    assign msk_arr[g] = msk_r;
  end

  always_comb begin
    cmp_byte = '0;
    msk_byte = '0;
    rb_byte  = '0;
    for (int i = 0; i < NB; i++) begin
      if (rd_pos == PW'(i)) begin
        cmp_byte = cmp_arr[i];
        msk_byte = msk_arr[i];
      end
      if (waddr == IX_AW'(i)) begin
        rb_byte = sel_cmp ? cmp_arr[i] : msk_arr[i];
      end
    end
  end
endmodule

// File: rtl/irwake_msgtrk.sv
module irwake_msgtrk
  import irwake_pkg::*;
#(
  parameter int unsigned NB = 11,
  parameter int unsigned PW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             byte_fire,
  input  logic [SYM_W-1:0] byte_data,
  input  logic             eom,
  input  logic [PW-1:0]    len_eff,
  input  logic [SYM_W-1:0] cmp_byte,
  input  logic [SYM_W-1:0] msk_byte,
  output logic [PW-1:0]    pos_q,
  output evt_t             evt
);
  logic          mism_q, mism_n, in_range, take, bad;
  logic [PW-1:0] pos_n;

  assign in_range = pos_q < PW'(NB);
  assign take     = enable && byte_fire && in_range;
  assign bad      = take && (pos_q < len_eff) &&
                    (|((byte_data ^ cmp_byte) & msk_byte));
  assign pos_n    = pos_q + PW'(take);
  assign mism_n   = mism_q | bad;

  always_comb begin
    evt.buff    = enable && byte_fire && !in_range;
    evt.msg_end = enable && eom;
    evt.rep     = enable && eom && (pos_n == '0);
    evt.match   = enable && eom && (pos_n != '0) && !mism_n &&
                  (pos_n >= len_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      mism_q <= 1'b0;
    end else if (!enable || eom) begin
      pos_q  <= '0;
      mism_q <= 1'b0;
    end else begin
      pos_q  <= pos_n;
      mism_q <= mism_n;
    end
  end
endmodule

// File: rtl/irwake_status.sv
module irwake_status
  import irwake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  evt_t       evt,
  input  logic       clr_wr,
  input  logic [7:0] clr_mask,
  input  logic       en_wr,
  input  logic [2:0] en_wdata,
  output logic [7:0] stat_q,
  output logic [2:0] en_q,
  output logic       wake
);
  logic [7:0] set_vec, clr_vec;

  always_comb begin
    set_vec           = '0;
    set_vec[ST_MATCH] = evt.match;
    set_vec[ST_END]   = evt.msg_end;
    set_vec[ST_BUFF]  = evt.buff;
    set_vec[ST_REP]   = evt.rep;
    clr_vec           = clr_wr ? clr_mask : 8'h00;
  end

  for (genvar g = 0; g < 8; g++) begin : g_flag
    if (ST_IMPL[g]) begin : g_impl
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (set_vec[g]) flag_q <= 1'b1;
        else if (clr_vec[g]) flag_q <= 1'b0;
      end
      assign stat_q[g] = flag_q;
    end else begin : g_none
      assign stat_q[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_wdata;
  end

  assign wake = |(stat_q[2:0] & en_q);
endmodule

// File: rtl/irwake_matcher.sv
module irwake_matcher
  import irwake_pkg::*;
#(
  parameter int unsigned NB = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sym_valid,
  output logic       sym_ready,
  input  logic [7:0] sym_data,
  input  logic       sym_eom,
  output logic       wake
);
  localparam int unsigned PW = $clog2(NB + 1);

  logic             ctrl_q;
  logic [3:0]       len_q;
  logic [PW-1:0]    len_eff, trk_pos;
  logic [7:0]       idx_q, stat_q;
  logic [2:0]       en_q;
  logic [SYM_W-1:0] cmp_byte, msk_byte, rb_byte;
  evt_t             evt;

  assign sym_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 1'b0;
      len_q  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) ctrl_q <= reg_wdata[0];
      if (reg_addr == A_LEN)  len_q  <= reg_wdata[3:0];
    end
  end

  assign len_eff = (len_q > 4'(NB)) ? PW'(NB) : PW'(len_q);

  irwake_patmem #(.NB(NB), .PW(PW)) u_pat (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (reg_wr && reg_addr == A_INDEX),
    .dat_wr   (reg_wr && reg_addr == A_DATA),
    .wdata    (reg_wdata),
    .rd_pos   (trk_pos),
    .idx_q    (idx_q),
    .cmp_byte (cmp_byte),
    .msk_byte (msk_byte),
    .rb_byte  (rb_byte)
  );

  irwake_msgtrk #(.NB(NB), .PW(PW)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (ctrl_q),
    .byte_fire (sym_valid && sym_ready),
    .byte_data (sym_data),
    .eom       (sym_eom),
    .len_eff   (len_eff),
    .cmp_byte  (cmp_byte),
    .msk_byte  (msk_byte),
    .pos_q     (trk_pos),
    .evt       (evt)
  );

  irwake_status u_st (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .clr_wr   (reg_wr && reg_addr == A_STAT),
    .clr_mask (reg_wdata),
    .en_wr    (reg_wr && reg_addr == A_EVEN),
    .en_wdata (reg_wdata[2:0]),
    .stat_q   (stat_q),
    .en_q     (en_q),
    .wake     (wake)
  );

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {7'b0, ctrl_q};
      A_STAT:  reg_rdata = stat_q;
      A_EVEN:  reg_rdata = {5'b0, en_q};
      A_INDEX: reg_rdata = idx_q;
      A_DATA:  reg_rdata = rb_byte;
      A_LEN:   reg_rdata = {4'b0, len_q};
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/irwake_checker.sv
module irwake_checker #(
  parameter int unsigned NB = 11,
  parameter int unsigned PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [7:0]    reg_wdata,
  input logic          sym_eom,
  input logic          wake,
  input logic [7:0]    stat,
  input logic          ctrl,
  input logic [PW-1:0] pos
);
  // R3: MATCH only rises after an enabled end-of-message
  p_match_after_eom_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[0]) |-> $past(sym_eom && ctrl));

  // R4: every enabled end-of-message leaves MSG_END set
  p_end_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_eom && ctrl) |=> stat[1]);

  // R5: message position never passes the window
  p_pos_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= PW'(NB));

  // R6: REPEAT only rises after an enabled end-of-message
  p_rep_after_eom_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[4]) |-> $past(sym_eom && ctrl));

  // R7: a clear with no competing event removes MSG_END
  p_w1c_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1 && reg_wdata[1] && !(sym_eom && ctrl))
    |=> !stat[1]);

  // R8: wake needs at least one event flag
  p_wake_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (stat[2:0] != 3'b000));

  // R9: no status bit rises while the receiver is off
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl |=> ((stat & ~$past(stat)) == 8'h00));
endmodule

bind irwake_matcher irwake_checker #(.NB(NB), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .sym_eom   (sym_eom),
  .wake      (wake),
  .stat      (stat_q),
  .ctrl      (ctrl_q),
  .pos       (trk_pos)
);

// File: tb/irwake_matcher_tb.sv
`timescale 1ns/1ps
module irwake_matcher_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd1;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sym_valid = 1'b0;
  logic       sym_ready;
  logic [7:0] sym_data = 8'h00;
  logic       sym_eom = 1'b0;
  logic       wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irwake_matcher dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sym_valid(sym_valid),
    .sym_ready(sym_ready), .sym_data(sym_data), .sym_eom(sym_eom), .wake(wake)
  );

  // behavioural reference model
  int m_cmp [16];
  int m_msk [16];
  int m_idx, m_ctrl, m_stat, m_en, m_len, m_pos;
  bit m_mism;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_cmp[i] = 0; m_msk[i] = 0; end
      m_idx = 0; m_ctrl = 0; m_stat = 0; m_en = 0; m_len = 0;
      m_pos = 0; m_mism = 0;
    end else begin
      int setv, eff, a;
      setv = 0;
      eff = (m_len > 11) ? 11 : m_len;
      if (m_ctrl != 0) begin
        if (sym_valid) begin
          if (m_pos < 11) begin
            if (m_pos < eff && (((sym_data ^ m_cmp[m_pos]) & m_msk[m_pos]) != 0))
              m_mism = 1;
            m_pos++;
          end else setv |= 4;
        end
        if (sym_eom) begin
          setv |= 2;
          if (m_pos == 0) setv |= 16;
          else if (!m_mism && m_pos >= eff) setv |= 1;
          m_pos = 0; m_mism = 0;
        end
      end else begin
        m_pos = 0; m_mism = 0;
      end
      if (reg_wr && reg_addr == 3'd1) m_stat &= ~(reg_wdata & 8'h17);
      m_stat |= setv;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: m_ctrl = reg_wdata & 1;
          3'd2: m_en = reg_wdata & 7;
          3'd3: m_idx = reg_wdata & 8'h3F;
          3'd4: begin
            a = m_idx & 15;
            if (a < 11) begin
              if (m_idx & 8'h10) m_cmp[a] = reg_wdata;
              if (m_idx & 8'h20) m_msk[a] = reg_wdata;
            end
            m_idx = (m_idx & 8'h30) | ((a + 1) & 15);
          end
          3'd5: m_len = reg_wdata & 15;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model, 5 ns after each rising edge
  always begin
    @(posedge clk);
    #5;
    if (rst_n && !done) begin
      chk("R8 wake vs model", int'(wake), ((m_stat & m_en & 7) != 0) ? 1 : 0);
      chk("R10 sym_ready", int'(sym_ready), 1);
      if (reg_addr == 3'd1) chk("R7 status vs model", int'(reg_rdata), m_stat);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd1;
  endtask

  task automatic snd(input logic [7:0] d, input bit e);
    @(negedge clk);
    sym_valid = 1'b1; sym_data = d; sym_eom = e;
    @(negedge clk);
    sym_valid = 1'b0; sym_eom = 1'b0;
  endtask

  task automatic eom_only();
    @(negedge clk);
    sym_eom = 1'b1;
    @(negedge clk);
    sym_eom = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = int'(reg_rdata);
    reg_addr = 3'd1;
  endtask

  task automatic msg4(input logic [7:0] b2);
    snd(8'h30, 0); snd(8'h31, 0); snd(b2, 0); snd(8'h33, 1);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd1, v); chk("R11 status after reset", v, 0);
    rd(3'd3, v); chk("R11 index after reset", v, 0);
    rd(3'd4, v); chk("R11 mask byte after reset", v, 0);
    chk("R11 wake after reset", int'(wake), 0);

    wr(3'd3, 8'h10);
    for (int i = 0; i < 11; i++) wr(3'd4, 8'h30 + 8'(i));
    rd(3'd3, v); chk("R1 index after 11 writes", v, 8'h1B);
    wr(3'd3, 8'h20);
    for (int i = 0; i < 11; i++) wr(3'd4, (i == 2) ? 8'h0F : 8'hFF);
    wr(3'd3, 8'h13); rd(3'd4, v); chk("R1 compare readback", v, 8'h33);
    wr(3'd3, 8'h22); rd(3'd4, v); chk("R1 mask readback", v, 8'h0F);

    wr(3'd2, 8'h07); wr(3'd5, 8'h04); wr(3'd0, 8'h01);

    msg4(8'h32);
    rd(3'd1, v); chk("R3 R4 full match", v, 8'h03);
    chk("R8 wake on match", int'(wake), 1);
    wr(3'd1, 8'h17);
    rd(3'd1, v); chk("R7 clear by writing 1", v, 0);
    chk("R8 wake drops after clear", int'(wake), 0);

    msg4(8'hF2);
    rd(3'd1, v); chk("R2 masked-out bits ignored", v, 8'h03);
    wr(3'd1, 8'h17);
    msg4(8'h36);
    rd(3'd1, v); chk("R2 masked bit mismatch", v, 8'h02);
    wr(3'd1, 8'h17);

    snd(8'h30, 0); snd(8'h31, 0); snd(8'h32, 0); snd(8'h33, 0); snd(8'h99, 1);
    rd(3'd1, v); chk("R3 byte beyond length not compared", v, 8'h03);
    wr(3'd1, 8'h17);
    snd(8'h30, 0); snd(8'h31, 0); snd(8'h32, 1);
    rd(3'd1, v); chk("R3 short message no match", v, 8'h02);
    wr(3'd1, 8'h17);

    wr(3'd5, 8'h0F);
    for (int i = 0; i < 11; i++) snd(8'h30 + 8'(i), 0);
    snd(8'h00, 0); snd(8'h00, 1);
    rd(3'd1, v); chk("R5 overflow sets BUFF, extra bytes ignored", v, 8'h07);
    wr(3'd1, 8'h17); wr(3'd5, 8'h04);

    eom_only();
    rd(3'd1, v); chk("R6 empty message sets REPEAT", v, 8'h12);
    chk("R8 wake from MSG_END", int'(wake), 1);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h02; sym_eom = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; sym_eom = 1'b0;
    rd(3'd1, v); chk("R7 set wins over clear", v, 8'h12);
    wr(3'd1, 8'h17);

    wr(3'd2, 8'h01);
    snd(8'h30, 1);
    rd(3'd1, v); chk("R8 end without match", v, 8'h02);
    chk("R8 disabled event gives no wake", int'(wake), 0);
    wr(3'd1, 8'h17); wr(3'd2, 8'h07);

    wr(3'd0, 8'h00);
    msg4(8'h32);
    rd(3'd1, v); chk("R9 receiver off sets nothing", v, 0);
    chk("R9 wake stays low", int'(wake), 0);
    wr(3'd0, 8'h01);
    snd(8'h30, 0); snd(8'h31, 0);
    wr(3'd0, 8'h00); wr(3'd0, 8'h01);
    snd(8'h32, 0); snd(8'h33, 1);
    rd(3'd1, v); chk("R9 partial message dropped", v, 8'h02);
    chk("R10 ready held high", int'(sym_ready), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule